// File: doc/BRIEF.md
# Rotating Register File

This block is a register file for software-pipelined loops. Its entries are split into a static region, addressed directly by index, and a rotating region whose logical indices are offset by an internal base register before they reach storage. A rotating access to logical index i lands in physical rotating slot (base + i) mod N_ROT. A single-cycle loop-step pulse moves the base down by one, so every rotating value is renamed in one step. This gives each loop iteration fresh register names without any copying.

There are two combinational read ports and one write port. Each port has its own select bit that picks between the static and rotating regions. The data width is a parameter, so the same block can serve a one-bit predicate file. Register read and write are plain control-style pins with no handshake: a write with `wr_en` high always completes at the next clock edge, and a read is always available in the same cycle. Reset clears the base and every entry.

Top module: `rrf_top`

## Requirements
- R1: While reset is asserted and right after it is released, the base is zero and every static and rotating entry reads as zero.
- R2: A static access (select bit 0) to index k < N_STATIC reads or writes static entry k. Neither the base nor a loop step changes which entry that is.
- R3: A rotating access (select bit 1) to logical index i < N_ROT maps to physical rotating slot (base + i) mod N_ROT. This holds for rotating sizes that are not powers of two.
- R4: Each loop-step pulse decrements the base by one, modulo N_ROT, so a step from 0 gives N_ROT-1. After N_ROT steps the mapping is back where it started. With no pulse, the base holds.
- R5: After one loop step and no write, the value that was readable as rotating r[i] is readable as r[(i+1) mod N_ROT].
- R6: When a write and a loop step happen in the same cycle, the write address is mapped with the base as it was before the step.
- R7: Reads are combinational. A read of the entry being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R8: The static and rotating regions never alias. Writes to one region and loop steps leave every entry of the other region unchanged.
- R9: An out-of-range index (static k >= N_STATIC, or rotating i >= N_ROT) reads as zero, and a write to it changes no entry.
- R10: The block works unchanged with DATA_W = 1 and a rotating size of 3.
- R11: The two read ports are independent. Each one can select either region and any index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_step | input | 1 | Loop-closing pulse; decrements the base |
| rd0_rot | input | 1 | Read port 0 region select (1 = rotating) |
| rd0_idx | input | IDX_W | Read port 0 logical index |
| rd0_data | output | DATA_W | Read port 0 data |
| rd1_rot | input | 1 | Read port 1 region select (1 = rotating) |
| rd1_idx | input | IDX_W | Read port 1 logical index |
| rd1_data | output | DATA_W | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_rot | input | 1 | Write region select (1 = rotating) |
| wr_idx | input | IDX_W | Write logical index |
| wr_data | input | DATA_W | Write data |

## Verification
The base cannot be seen directly at the ports. If it is wrong, every rotating read is rotated by the error, and this shows up on the first rotating read after the bad step, one cycle after the loop-step pulse. An aliasing fault or a wrong region decode makes a static entry change when only rotating entries were written. This is caught when all logical entries are swept from both read ports after each scenario. A wrong write mapping during a simultaneous step puts the value one logical name away from r[i+1], and this is visible in the next cycle.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  // Physical rotating slot for a logical index, given base < n and idx < n.
  function automatic int unsigned rot_phys(int unsigned base, int unsigned idx,
                                           int unsigned n);
    int unsigned s;
    s = base + idx;
    if (s >= n) s = s - n;
    return s;
  endfunction

  // Base value after one loop step, wrapping below zero.
  function automatic int unsigned rot_prev(int unsigned base, int unsigned n);
    return (base == 0) ? n - 1 : base - 1;
  endfunction

endpackage

// File: rtl/rrf_base.sv
module rrf_base #(
  parameter int unsigned N_ROT  = 6,
  parameter int unsigned BASE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  output logic [BASE_W-1:0] base_o
);
  logic [BASE_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (shift_i) base_q <= BASE_W'(rrf_pkg::rot_prev(32'(base_q), N_ROT));
  end

  assign base_o = base_q;
endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
  parameter int unsigned N_STATIC = 8,
  parameter int unsigned N_ROT    = 6,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned BASE_W   = 3,
  parameter int unsigned SLOT_W   = 4
) (
  input  logic              rot_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BASE_W-1:0] base_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o
);
  // Storage layout: static entries occupy slots [0, N_STATIC), rotating
  // entries occupy [N_STATIC, N_STATIC+N_ROT), so the two never overlap.
  always_comb begin
    hit_o  = rot_i ? (32'(idx_i) < N_ROT) : (32'(idx_i) < N_STATIC);
    slot_o = '0;
    if (hit_o) begin
      if (rot_i)
        slot_o = SLOT_W'(N_STATIC + rrf_pkg::rot_phys(32'(base_i), 32'(idx_i), N_ROT));
      else
        slot_o = SLOT_W'(idx_i);
    end
  end
endmodule

// File: rtl/rrf_store.sv
module rrf_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_SLOT = 14,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned N_RD   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [SLOT_W-1:0]             wslot_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [N_RD-1:0][SLOT_W-1:0]   rslot_i,
  output logic [N_RD-1:0][DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] mem [N_SLOT];

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (we_i && (wslot_i == SLOT_W'(g)))    mem[g] <= wdata_i;
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rdata_o[r] = (32'(rslot_i[r]) < N_SLOT) ? mem[rslot_i[r]] : '0;
  end
endmodule

// File: rtl/rrf_top.sv
module rrf_top #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_STATIC = 8,
  parameter int unsigned N_ROT    = 6,
  parameter int unsigned IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_step,
  input  logic              rd0_rot,
  input  logic [IDX_W-1:0]  rd0_idx,
  output logic [DATA_W-1:0] rd0_data,
  input  logic              rd1_rot,
  input  logic [IDX_W-1:0]  rd1_idx,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic              wr_rot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned BASE_W = (N_ROT > 1) ? $clog2(N_ROT) : 1;
  localparam int unsigned N_SLOT = N_STATIC + N_ROT;
  localparam int unsigned SLOT_W = $clog2(N_SLOT);
  localparam int unsigned N_ACC  = 3;  // ports 0,1 read; port 2 write

  logic [BASE_W-1:0]             base_q;
  logic [N_ACC-1:0]              acc_rot;
  logic [N_ACC-1:0][IDX_W-1:0]   acc_idx;
  logic [N_ACC-1:0]              acc_hit;
  logic [N_ACC-1:0][SLOT_W-1:0]  acc_slot;
  logic [1:0][SLOT_W-1:0]        rd_slot;
  logic [1:0][DATA_W-1:0]        rd_raw;

  rrf_base #(.N_ROT(N_ROT), .BASE_W(BASE_W)) u_base (
    .clk(clk), .rst_n(rst_n), .shift_i(loop_step), .base_o(base_q)
  );

  assign acc_rot = {wr_rot, rd1_rot, rd0_rot};
  assign acc_idx = {wr_idx, rd1_idx, rd0_idx};

  // The write port sees the current (pre-step) base, so a write issued with
  // a step lands where the old mapping points.
  for (genvar a = 0; a < N_ACC; a++) begin : g_map
    rrf_map #(
      .N_STATIC(N_STATIC), .N_ROT(N_ROT), .IDX_W(IDX_W),
      .BASE_W(BASE_W), .SLOT_W(SLOT_W)
    ) u_map (
      .rot_i(acc_rot[a]), .idx_i(acc_idx[a]), .base_i(base_q),
      .hit_o(acc_hit[a]), .slot_o(acc_slot[a])
    );
  end

  assign rd_slot = {acc_slot[1], acc_slot[0]};

  rrf_store #(
    .DATA_W(DATA_W), .N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .N_RD(2)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_en && acc_hit[2]), .wslot_i(acc_slot[2]), .wdata_i(wr_data),
    .rslot_i(rd_slot), .rdata_o(rd_raw)
  );

  assign rd0_data = acc_hit[0] ? rd_raw[0] : '0;
  assign rd1_data = acc_hit[1] ? rd_raw[1] : '0;
endmodule

// File: rtl/rrf_top_chk.sv
module rrf_top_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_STATIC = 8,
  parameter int unsigned N_ROT    = 6,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned BASE_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loop_step,
  input logic [BASE_W-1:0] base_q,
  input logic              rd0_rot,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [DATA_W-1:0] rd0_data,
  input logic              rd1_rot,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic [DATA_W-1:0] rd1_data,
  input logic              wr_en
);
  // R1: base held at zero during reset
  always @(posedge clk) begin
    if (!rst_n) p_reset_base_r1: assert (base_q == '0);
  end

  p_base_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(base_q) < N_ROT);

  p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_step |=> base_q == (($past(base_q) == '0) ? BASE_W'(N_ROT - 1)
                                                   : $past(base_q) - 1'b1));

  p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_step |=> $stable(base_q));

  // R5: with no write, r[i] before a step equals r[i+1] after it (port 0)
  p_rotate_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && loop_step && rd0_rot && (32'(rd0_idx) + 1 < N_ROT))
    |=> (!rd0_rot || rd0_idx != $past(rd0_idx) + 1'b1
         || rd0_data == $past(rd0_data)));

  // R8: with no write, a static read at the same index is unchanged, step or not
  p_static_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd0_rot)
    |=> (rd0_rot || rd0_idx != $past(rd0_idx) || rd0_data == $past(rd0_data)));

  p_oor_rot_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_rot && 32'(rd0_idx) >= N_ROT) |-> rd0_data == '0);

  p_oor_static_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd1_rot && 32'(rd1_idx) >= N_STATIC) |-> rd1_data == '0);
endmodule

bind rrf_top rrf_top_chk #(
  .DATA_W(DATA_W), .N_STATIC(N_STATIC), .N_ROT(N_ROT),
  .IDX_W(IDX_W), .BASE_W(BASE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .loop_step(loop_step), .base_q(base_q),
  .rd0_rot(rd0_rot), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
  .rd1_rot(rd1_rot), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
  .wr_en(wr_en)
);

// File: tb/tb_rrf_top.sv
`timescale 1ns/1ps
module tb_rrf_top;
  localparam int NS = 8;
  localparam int NR = 6;
  localparam int NIDX = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loop_step = 1'b0;
  logic        rd0_rot = 1'b0, rd1_rot = 1'b0;
  logic [3:0]  rd0_idx = '0, rd1_idx = '0;
  logic [31:0] rd0_data, rd1_data;
  logic        wr_en = 1'b0, wr_rot = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;

  // narrow instance: one-bit data, 2 static, 3 rotating
  logic        n_step = 1'b0;
  logic        n_rd0_rot = 1'b0, n_rd1_rot = 1'b0;
  logic [1:0]  n_rd0_idx = '0, n_rd1_idx = '0;
  logic [0:0]  n_rd0_data, n_rd1_data;
  logic        n_wr_en = 1'b0, n_wr_rot = 1'b0;
  logic [1:0]  n_wr_idx = '0;
  logic [0:0]  n_wr_data = '0;

  always #10 clk = ~clk;  // 50 MHz

  rrf_top dut (
    .clk(clk), .rst_n(rst_n), .loop_step(loop_step),
    .rd0_rot(rd0_rot), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_rot(rd1_rot), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_rot(wr_rot), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  rrf_top #(.DATA_W(1), .N_STATIC(2), .N_ROT(3), .IDX_W(2)) dut_n (
    .clk(clk), .rst_n(rst_n), .loop_step(n_step),
    .rd0_rot(n_rd0_rot), .rd0_idx(n_rd0_idx), .rd0_data(n_rd0_data),
    .rd1_rot(n_rd1_rot), .rd1_idx(n_rd1_idx), .rd1_data(n_rd1_data),
    .wr_en(n_wr_en), .wr_rot(n_wr_rot), .wr_idx(n_wr_idx), .wr_data(n_wr_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] st [NS];
  logic [31:0] rt [NR];
  int          base_m = 0;

  function automatic logic [31:0] model_rd(logic rot, int idx);
    if (rot) return (idx < NR) ? rt[(base_m + idx) % NR] : 32'h0;
    return (idx < NS) ? st[idx] : 32'h0;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // sweep every logical entry of both regions through both read ports
  task automatic verify_all(string req);
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < NIDX; i++) begin
        @(negedge clk);
        rd0_rot = r[0];  rd0_idx = 4'(i);
        rd1_rot = ~r[0]; rd1_idx = 4'(NIDX - 1 - i);  // R11: independent ports
        #1;
        check(req, $sformatf("p0 rot=%0d idx=%0d", r, i), rd0_data, model_rd(r[0], i));
        check(req, $sformatf("p1 rot=%0d idx=%0d", 1 - r, NIDX - 1 - i),
              rd1_data, model_rd(~r[0], NIDX - 1 - i));
      end
    end
  endtask

  task automatic peek(logic rot, int idx, output logic [31:0] d);
    @(negedge clk);
    rd0_rot = rot; rd0_idx = 4'(idx);
    #1;
    d = rd0_data;
  endtask

  task automatic op(logic en, logic rot, int idx, logic [31:0] d, logic step);
    @(negedge clk);
    wr_en = en; wr_rot = rot; wr_idx = 4'(idx); wr_data = d; loop_step = step;
    @(posedge clk);
    if (en) begin
      if (rot && idx < NR)       rt[(base_m + idx) % NR] = d;
      else if (!rot && idx < NS) st[idx] = d;
    end
    if (step) base_m = (base_m + NR - 1) % NR;
    @(negedge clk);
    wr_en = 1'b0; loop_step = 1'b0;
  endtask

  task automatic t_reset();
    verify_all("R1");
  endtask

  task automatic t_static();
    for (int i = 0; i < NS; i++) op(1'b1, 1'b0, i, 32'hA000_0000 + 32'(i), 1'b0);
    verify_all("R2");
    verify_all("R11");
  endtask

  task automatic t_rot_map();
    for (int i = 0; i < NR; i++) op(1'b1, 1'b1, i, 32'hB000_0010 + 32'(i), 1'b0);
    verify_all("R3");
  endtask

  task automatic t_shift();
    logic [31:0] old [NR];
    logic [31:0] d;
    for (int i = 0; i < NR; i++) peek(1'b1, i, old[i]);
    op(1'b0, 1'b0, 0, 32'h0, 1'b1);
    for (int i = 0; i + 1 < NR; i++) begin
      peek(1'b1, i + 1, d);
      check("R5", $sformatf("r[%0d] after step", i + 1), d, old[i]);
    end
    peek(1'b1, 0, d);
    check("R4", "wrap r[0] after step from base 0", d, old[NR-1]);
    verify_all("R3");
    for (int k = 1; k < NR; k++) op(1'b0, 1'b0, 0, 32'h0, 1'b1);
    for (int i = 0; i < NR; i++) begin
      peek(1'b1, i, d);
      check("R4", $sformatf("r[%0d] after full turn", i), d, old[i]);
    end
    op(1'b0, 1'b0, 0, 32'h0, 1'b1);
    op(1'b0, 1'b0, 0, 32'h0, 1'b1);
    verify_all("R5");
  endtask

  task automatic t_write_shift();
    logic [31:0] d;
    op(1'b1, 1'b1, 2, 32'hC0DE_0006, 1'b1);
    peek(1'b1, 3, d);
    check("R6", "write with step visible at r[3]", d, 32'hC0DE_0006);
    verify_all("R6");
  endtask

  task automatic t_same_cycle();
    logic [31:0] oldv;
    oldv = model_rd(1'b1, 1);
    @(negedge clk);
    wr_en = 1'b1; wr_rot = 1'b1; wr_idx = 4'd1; wr_data = 32'h5A5A_1111;
    rd0_rot = 1'b1; rd0_idx = 4'd1;
    #1;
    check("R7", "read during write returns old", rd0_data, oldv);
    @(posedge clk);
    rt[(base_m + 1) % NR] = 32'h5A5A_1111;
    #1;
    check("R7", "read after edge returns new", rd0_data, 32'h5A5A_1111);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_alias();
    for (int i = 0; i < NR; i++) op(1'b1, 1'b1, i, 32'hD000_0000 + 32'(i), 1'b0);
    verify_all("R8");
    for (int i = 0; i < NS; i++) op(1'b1, 1'b0, i, 32'hE000_0000 + 32'(i), i == 3);
    verify_all("R8");
  endtask

  task automatic t_oor();
    op(1'b1, 1'b1, NR, 32'hDEAD_0001, 1'b0);
    op(1'b1, 1'b1, 15, 32'hDEAD_0002, 1'b0);
    op(1'b1, 1'b0, NS, 32'hDEAD_0003, 1'b0);
    op(1'b1, 1'b0, 15, 32'hDEAD_0004, 1'b0);
    verify_all("R9");
  endtask

  task automatic n_op(logic en, logic rot, int idx, logic d, logic step);
    @(negedge clk);
    n_wr_en = en; n_wr_rot = rot; n_wr_idx = 2'(idx); n_wr_data = d; n_step = step;
    @(negedge clk);
    n_wr_en = 1'b0; n_step = 1'b0;
  endtask

  task automatic n_expect(logic [2:0] exp_r, logic exp_s0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      n_rd0_rot = 1'b1; n_rd0_idx = 2'(i);
      n_rd1_rot = 1'b0; n_rd1_idx = 2'd0;
      #1;
      check("R10", $sformatf("narrow r[%0d]", i), 32'(n_rd0_data), 32'(exp_r[i]));
      check("R10", "narrow static s0", 32'(n_rd1_data), 32'(exp_s0));
    end
  endtask

  task automatic t_narrow();
    n_op(1'b1, 1'b0, 0, 1'b1, 1'b0);
    n_op(1'b1, 1'b1, 0, 1'b1, 1'b0);
    n_expect(3'b001, 1'b1);
    n_op(1'b0, 1'b0, 0, 1'b0, 1'b1);
    n_expect(3'b010, 1'b1);
    n_op(1'b0, 1'b0, 0, 1'b0, 1'b1);
    n_expect(3'b100, 1'b1);
    n_op(1'b0, 1'b0, 0, 1'b0, 1'b1);
    n_expect(3'b001, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < NS; i++) st[i] = '0;
    for (int i = 0; i < NR; i++) rt[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_static();
    t_rot_map();
    t_shift();
    t_write_shift();
    t_same_cycle();
    t_alias();
    t_oor();
    t_narrow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule